// File: doc/BRIEF.md
# Bus Clock Enable Divider Tree

This block turns one master clock into a tree of clock-enable pulses. Each pulse is one master cycle wide and marks an active edge of a slower bus clock. A base divider sets the pace for two processor enables and the AHB-domain enable. Three APB enables and a trace enable are derived from the base pulses. A watchdog counter enable is derived from the pulses of the first APB divider. Every divider reads its own ratio code from a small register file, and that file is loaded through a single-cycle write port.

A power-mode input gates the outputs. In sleep, only the AHB/processor enable stops and the free-running processor enable keeps going. In timer and stop modes every output is held low. Two software gate bits can each stop one of the second and third APB enables on its own.

There are two synchronous resets. A hard reset restores every setting. A software reset restarts the counters but keeps the ratio codes. A new ratio never cuts a period short: it is picked up when the running period of that divider completes.

Top module: `bus_clk_tree`

## Requirements
- R1: Address 0 holds a 4-bit base code c. Its ratio is c+1 rounded to the nearest power of two, with ties going to the smaller one (3→2, 6→4, 7→8, 12→8, 13→16). fclk_en and hclk_en pulse once every ratio master cycles. The code is 0 after hard reset, which gives one pulse every cycle.
- R2: Addresses 1, 2 and 3 hold 3-bit codes for APB clocks 0, 1 and 2, rounded the same way. pclk_en[k] pulses once every ratio base pulses, and always in a cycle that also carries a base pulse.
- R3: Bit 0 of address 4 sets the trace ratio relative to the base pulses: 0 gives 1/1 and 1 gives 1/2.
- R4: Address 5 holds a 3-bit code, rounded as in R1, that divides the pulses of APB clock 0. wdog_en therefore only pulses in cycles in which pclk_en[0] pulses.
- R5: A new ratio takes effect only once the divider's current period has completed. Every interval seen across a change equals either the old period or the new one.
- R6: With pwr_mode=1 (sleep), hclk_en stays low. fclk_en, pclk_en, trace_en and wdog_en keep pulsing at their programmed rates.
- R7: With pwr_mode=2 (timer) or pwr_mode=3 (stop), all outputs stay low.
- R8: At address 6, bit 0 = 1 lets pclk_en[1] run and bit 1 = 1 lets pclk_en[2] run. A 0 in either bit stops only that enable. Both bits return to 1 on either reset.
- R9: soft_rst keeps every ratio code and restarts the counters. rst returns all ratio codes to 0.
- R10: All outputs are registered. They are low while either reset is held, and a pwr_mode change is visible one master cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous hard reset, active high |
| soft_rst | input | 1 | synchronous software reset, active high; ratio codes kept |
| pwr_mode | input | 2 | 0 run, 1 sleep, 2 timer, 3 stop |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register address |
| wr_data | input | 4 | register write data |
| fclk_en | output | 1 | free-running processor clock enable |
| hclk_en | output | 1 | AHB/processor clock enable |
| pclk_en | output | 3 | APB clock enables 0..2 |
| trace_en | output | 1 | trace clock enable |
| wdog_en | output | 1 | watchdog counter clock enable |

## Verification
A table of eight code sets is applied in turn, and the interval between pulses is measured on every output. The sets mix exact powers of two with codes that round up, codes that round down and codes that tie. A wrong rounding rule or a wrong cascade point therefore shows up as a period mismatch. The longest chain of 16×8×8 catches counters that are too narrow. A ratio write placed in the middle of a long base period separates a deferred update from an immediate one by checking for any odd interval. Pulse counts taken in each power mode and with each gate bit setting show which enables stop and which keep running. A software reset compared with a hard reset shows whether the ratio codes were kept or cleared.

// File: rtl/bct_pkg.sv
package bct_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_TIMER = 2'd2,
    PM_STOP  = 2'd3
  } pm_e;

  localparam int A_BASE  = 0;
  localparam int A_APB0  = 1;
  localparam int A_TRACE = 4;
  localparam int A_WDOG  = 5;
  localparam int A_GATE  = 6;

  // log2 of the power of two nearest to ratio; ties go to the smaller one
  function automatic int unsigned near_log2(input int unsigned ratio);
    int unsigned lg;
    int unsigned lo;
    lg = 0;
    for (int i = 0; i < 31; i++) begin
      if (ratio >= (32'd1 << i)) lg = i;
    end
    lo = 32'd1 << lg;
    if ((ratio - lo) > ((lo << 1) - ratio)) lg = lg + 1;
    return lg;
  endfunction

endpackage

// File: rtl/bct_cfg_regs.sv
module bct_cfg_regs
  import bct_pkg::*;
#(
  parameter int BASE_W = 4,
  parameter int APB_W  = 3,
  parameter int TRC_W  = 1,
  parameter int WDG_W  = 3,
  parameter int N_APB  = 3,
  parameter int ADDR_W = 3,
  localparam int DATA_W = BASE_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         soft_rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [BASE_W-1:0]            base_code,
  output logic [N_APB-1:0][APB_W-1:0]  apb_code,
  output logic [TRC_W-1:0]             trc_code,
  output logic [WDG_W-1:0]             wdg_code,
  output logic [N_APB-1:0]             apb_on
);

  logic [N_APB-1:1] gate_q;

  // ratio codes: cleared by hard reset only
  always_ff @(posedge clk) begin
    if (rst) begin
      base_code <= '0;
      trc_code  <= '0;
      wdg_code  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_BASE))  base_code <= wr_data[BASE_W-1:0];
      if (wr_addr == ADDR_W'(A_TRACE)) trc_code  <= wr_data[TRC_W-1:0];
      if (wr_addr == ADDR_W'(A_WDOG))  wdg_code  <= wr_data[WDG_W-1:0];
    end
  end

  for (genvar g = 0; g < N_APB; g++) begin : g_apb
    logic [APB_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst) code_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_APB0 + g)) code_q <= wr_data[APB_W-1:0];
    end
    assign apb_code[g] = code_q;
  end

  // supply gates: re-enabled by either reset
  always_ff @(posedge clk) begin
    if (rst || soft_rst) gate_q <= '1;
    else if (wr_en && wr_addr == ADDR_W'(A_GATE)) gate_q <= wr_data[N_APB-2:0];
  end

  assign apb_on = {gate_q, 1'b1};

endmodule

// File: rtl/bct_div_stage.sv
module bct_div_stage
  import bct_pkg::*;
#(
  parameter int CODE_W = 3,
  localparam int CNT_W = CODE_W
) (
  input  logic              clk,
  input  logic              rst_hard,
  input  logic              rst_soft,
  input  logic [CODE_W-1:0] code,
  input  logic              in_tick,
  output logic              out_tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_q;
  logic [CNT_W-1:0] term_new;
  logic             at_term;

  assign term_new = CNT_W'((32'd1 << near_log2(32'(code) + 32'd1)) - 32'd1);
  assign at_term  = (cnt_q == term_q);
  assign out_tick = in_tick && at_term;

  // the active terminal count is reloaded only when a period completes
  always_ff @(posedge clk) begin
    if (rst_hard) begin
      cnt_q  <= '0;
      term_q <= '0;
    end else if (rst_soft) begin
      cnt_q  <= '0;
      term_q <= term_new;
    end else if (in_tick) begin
      if (at_term) begin
        cnt_q  <= '0;
        term_q <= term_new;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bct_out_gate.sv
module bct_out_gate
  import bct_pkg::*;
#(
  parameter int N_APB = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       pwr_mode,
  input  logic             base_tick,
  input  logic [N_APB-1:0] apb_tick,
  input  logic [N_APB-1:0] apb_on,
  input  logic             trc_tick,
  input  logic             wdg_tick,
  output logic             fclk_q,
  output logic             hclk_q,
  output logic [N_APB-1:0] apb_q,
  output logic             trc_q,
  output logic             wdg_q
);

  pm_e  mode;
  logic bus_ok;
  logic core_ok;

  assign mode    = pm_e'(pwr_mode);
  assign bus_ok  = (mode == PM_RUN) || (mode == PM_SLEEP);
  assign core_ok = (mode == PM_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      fclk_q <= 1'b0;
      hclk_q <= 1'b0;
      apb_q  <= '0;
      trc_q  <= 1'b0;
      wdg_q  <= 1'b0;
    end else begin
      fclk_q <= base_tick && bus_ok;
      hclk_q <= base_tick && core_ok;
      apb_q  <= apb_tick & apb_on & {N_APB{bus_ok}};
      trc_q  <= trc_tick && bus_ok;
      wdg_q  <= wdg_tick && bus_ok;
    end
  end

endmodule

// File: rtl/bus_clk_tree.sv
module bus_clk_tree
  import bct_pkg::*;
#(
  parameter int BASE_W = 4,
  parameter int APB_W  = 3,
  parameter int TRC_W  = 1,
  parameter int WDG_W  = 3,
  parameter int N_APB  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [1:0]        pwr_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BASE_W-1:0] wr_data,
  output logic              fclk_en,
  output logic              hclk_en,
  output logic [N_APB-1:0]  pclk_en,
  output logic              trace_en,
  output logic              wdog_en
);

  logic [BASE_W-1:0]           base_code;
  logic [N_APB-1:0][APB_W-1:0] apb_code;
  logic [TRC_W-1:0]            trc_code;
  logic [WDG_W-1:0]            wdg_code;
  logic [N_APB-1:0]            apb_on;
  logic                        base_tick;
  logic [N_APB-1:0]            apb_tick;
  logic                        trc_tick;
  logic                        wdg_tick;
  logic                        rst_any;

  assign rst_any = rst || soft_rst;

  bct_cfg_regs #(
    .BASE_W(BASE_W), .APB_W(APB_W), .TRC_W(TRC_W), .WDG_W(WDG_W),
    .N_APB(N_APB), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base_code(base_code), .apb_code(apb_code), .trc_code(trc_code),
    .wdg_code(wdg_code), .apb_on(apb_on)
  );

  bct_div_stage #(.CODE_W(BASE_W)) u_base (
    .clk(clk), .rst_hard(rst), .rst_soft(soft_rst), .code(base_code),
    .in_tick(1'b1), .out_tick(base_tick)
  );

  for (genvar g = 0; g < N_APB; g++) begin : g_apb
    bct_div_stage #(.CODE_W(APB_W)) u_apb (
      .clk(clk), .rst_hard(rst), .rst_soft(soft_rst), .code(apb_code[g]),
      .in_tick(base_tick), .out_tick(apb_tick[g])
    );
  end

  bct_div_stage #(.CODE_W(TRC_W)) u_trc (
    .clk(clk), .rst_hard(rst), .rst_soft(soft_rst), .code(trc_code),
    .in_tick(base_tick), .out_tick(trc_tick)
  );

  bct_div_stage #(.CODE_W(WDG_W)) u_wdg (
    .clk(clk), .rst_hard(rst), .rst_soft(soft_rst), .code(wdg_code),
    .in_tick(apb_tick[0]), .out_tick(wdg_tick)
  );

  bct_out_gate #(.N_APB(N_APB)) u_gate (
    .clk(clk), .rst(rst_any), .pwr_mode(pwr_mode),
    .base_tick(base_tick), .apb_tick(apb_tick), .apb_on(apb_on),
    .trc_tick(trc_tick), .wdg_tick(wdg_tick),
    .fclk_q(fclk_en), .hclk_q(hclk_en), .apb_q(pclk_en),
    .trc_q(trace_en), .wdg_q(wdog_en)
  );

endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
  parameter int N_APB = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic [1:0]       pwr_mode,
  input logic             fclk_en,
  input logic             hclk_en,
  input logic [N_APB-1:0] pclk_en,
  input logic             trace_en,
  input logic             wdog_en,
  input logic [N_APB-1:0] apb_on
);

  a_r2_apb_on_base: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (|pclk_en) |-> fclk_en);

  a_r3_trace_on_base: assert property (@(posedge clk) disable iff (rst || soft_rst)
    trace_en |-> fclk_en);

  a_r4_wdog_on_apb0: assert property (@(posedge clk) disable iff (rst || soft_rst)
    wdog_en |-> pclk_en[0]);

  a_r6_hclk_implies_fclk: assert property (@(posedge clk) disable iff (rst || soft_rst)
    hclk_en |-> fclk_en);

  a_r6_sleep_hclk_off: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (pwr_mode == 2'd1) |=> !hclk_en);

  a_r7_idle_all_off: assert property (@(posedge clk) disable iff (rst || soft_rst)
    pwr_mode[1] |=> ($countones({fclk_en, hclk_en, pclk_en, trace_en, wdog_en}) == 0));

  a_r8_gate_apb1: assert property (@(posedge clk) disable iff (rst || soft_rst)
    !apb_on[1] |=> !pclk_en[1]);

  a_r8_gate_apb2: assert property (@(posedge clk) disable iff (rst || soft_rst)
    !apb_on[2] |=> !pclk_en[2]);

endmodule

bind bus_clk_tree bct_checker #(.N_APB(N_APB)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .pwr_mode(pwr_mode),
  .fclk_en(fclk_en), .hclk_en(hclk_en), .pclk_en(pclk_en),
  .trace_en(trace_en), .wdog_en(wdog_en), .apb_on(apb_on)
);

// File: tb/tb_bus_clk_tree.sv
`timescale 1ns/1ps
module tb_bus_clk_tree;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0;
  logic [1:0] pwr_mode = 2'd0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       fclk_en, hclk_en, trace_en, wdog_en;
  logic [2:0] pclk_en;
  logic [6:0] ov;

  always #2.5 clk = ~clk;

  bus_clk_tree dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .pwr_mode(pwr_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fclk_en(fclk_en), .hclk_en(hclk_en), .pclk_en(pclk_en),
    .trace_en(trace_en), .wdog_en(wdog_en)
  );

  // index: 0 fclk, 1 hclk, 2..4 pclk0..2, 5 trace, 6 wdog
  assign ov = {wdog_en, trace_en, pclk_en, hclk_en, fclk_en};

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cyc = 0;
  int last_t[7];
  int intv[7];
  int pcnt[7];
  int odd_cnt = 0;
  int allow_a = 0;
  int allow_b = 0;

  // codes: base, apb0, apb1, apb2, trace, wdog ; expected ratios in the same order
  localparam int VEC [8][12] = '{
    '{ 1, 0, 1, 3, 1, 0,   2, 1, 2, 4, 2, 1},
    '{ 2, 2, 4, 6, 0, 1,   2, 2, 4, 8, 1, 2},
    '{ 5, 3, 5, 2, 1, 7,   4, 4, 4, 2, 2, 8},
    '{11, 7, 0, 1, 0, 6,   8, 8, 1, 2, 1, 8},
    '{12, 1, 7, 7, 1, 2,  16, 2, 8, 8, 2, 2},
    '{15, 7, 6, 3, 1, 7,  16, 8, 8, 4, 2, 8},
    '{ 6, 4, 2, 5, 0, 3,   8, 4, 2, 4, 1, 4},
    '{ 8, 0, 0, 0, 0, 0,   8, 1, 1, 1, 1, 1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    for (int i = 0; i < 7; i++) begin
      if (ov[i]) begin
        pcnt[i]++;
        if (last_t[i] >= 0) begin
          intv[i] = cyc - last_t[i];
          if (i == 1 && intv[i] != allow_a && intv[i] != allow_b) odd_cnt++;
        end
        last_t[i] = cyc;
      end
    end
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic clr();
    for (int i = 0; i < 7; i++) begin
      last_t[i] = -1;
      intv[i]   = -1;
      pcnt[i]   = 0;
    end
    odd_cnt = 0;
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = 3'(a);
    wr_data = 4'(d);
    step();
    wr_en   = 1'b0;
  endtask

  initial begin
    clr();
    steps(3);
    chk("R10 outputs low in reset", int'(ov), 0);
    rst = 1'b0;
    steps(4);
    clr();
    steps(40);
    for (int i = 0; i < 7; i++) chk($sformatf("R1 default ratio out%0d", i), intv[i], 1);

    // table walk: R1 R2 R3 R4
    for (int r = 0; r < 8; r++) begin
      for (int a = 0; a < 6; a++) wr(a, VEC[r][a]);
      steps(2200);
      clr();
      steps(2200);
      chk($sformatf("R1 row%0d fclk", r), intv[0], VEC[r][6]);
      chk($sformatf("R1 row%0d hclk", r), intv[1], VEC[r][6]);
      chk($sformatf("R2 row%0d pclk0", r), intv[2], VEC[r][6] * VEC[r][7]);
      chk($sformatf("R2 row%0d pclk1", r), intv[3], VEC[r][6] * VEC[r][8]);
      chk($sformatf("R2 row%0d pclk2", r), intv[4], VEC[r][6] * VEC[r][9]);
      chk($sformatf("R3 row%0d trace", r), intv[5], VEC[r][6] * VEC[r][10]);
      chk($sformatf("R4 row%0d wdog", r), intv[6], VEC[r][6] * VEC[r][7] * VEC[r][11]);
    end

    // R5: ratio change lands at the end of the running period
    for (int a = 1; a < 6; a++) wr(a, 0);
    wr(0, 15);
    steps(40);
    clr();
    allow_a = 16;
    allow_b = 2;
    while (!ov[1]) step();
    steps(6);
    wr(0, 1);
    steps(100);
    chk("R5 no truncated hclk interval", odd_cnt, 0);
    chk("R5 new base ratio active", intv[1], 2);

    // power modes with base 2, apb 2, trace 2, wdog 2
    for (int a = 0; a < 6; a++) wr(a, 1);
    steps(60);
    pwr_mode = 2'd1;
    steps(2);
    clr();
    steps(200);
    chk("R6 sleep hclk stopped", pcnt[1], 0);
    chk("R6 sleep fclk runs", pcnt[0], 100);
    chk("R6 sleep pclk0 runs", pcnt[2], 50);
    chk("R6 sleep trace runs", pcnt[5], 50);
    chk("R6 sleep wdog runs", pcnt[6], 25);
    pwr_mode = 2'd2;
    steps(2);
    clr();
    steps(200);
    chk("R7 timer all stopped", pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3] + pcnt[4] + pcnt[5] + pcnt[6], 0);
    pwr_mode = 2'd3;
    steps(2);
    clr();
    steps(200);
    chk("R7 stop all stopped", pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3] + pcnt[4] + pcnt[5] + pcnt[6], 0);
    pwr_mode = 2'd0;
    steps(2);
    clr();
    steps(200);
    chk("R6 run hclk resumes", pcnt[1], 100);

    // R8 gate bits
    wr(6, 2);
    steps(2);
    clr();
    steps(200);
    chk("R8 pclk1 gated off", pcnt[3], 0);
    chk("R8 pclk2 still on", pcnt[4], 50);
    chk("R8 pclk0 unaffected", pcnt[2], 50);
    wr(6, 1);
    steps(2);
    clr();
    steps(200);
    chk("R8 pclk2 gated off", pcnt[4], 0);
    chk("R8 pclk1 back on", pcnt[3], 50);

    // R9 soft reset keeps ratios; R8 gates return to on
    soft_rst = 1'b1;
    steps(2);
    chk("R10 outputs low in soft reset", int'(ov), 0);
    soft_rst = 1'b0;
    steps(40);
    clr();
    steps(200);
    chk("R9 soft reset keeps base", intv[1], 2);
    chk("R9 soft reset keeps pclk0", intv[2], 4);
    chk("R9 soft reset keeps wdog", intv[6], 8);
    chk("R8 soft reset reopens pclk2", intv[4], 4);

    // R9 hard reset clears ratios
    rst = 1'b1;
    steps(2);
    rst = 1'b0;
    steps(20);
    clr();
    steps(50);
    chk("R9 hard reset base", intv[1], 1);
    chk("R9 hard reset pclk0", intv[2], 1);
    chk("R9 hard reset wdog", intv[6], 1);

    // R10 mode change seen one cycle later
    pwr_mode = 2'd2;
    step();
    chk("R10 timer one cycle later", int'(ov), 0);
    pwr_mode = 2'd0;
    step();
    chk("R10 run one cycle later", int'(fclk_en), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule